// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block behaves like a small serial EEPROM of 128 bytes that talks over a three-wire link: a select line, a serial clock and one data line in each direction. It is meant to sit opposite a master controller inside a verification environment. The master can then issue real read, write and erase traffic and poll for completion, and its results can be checked against a device that follows the same rules as the real part. All logic runs on one system clock. The serial clock and the other pins are sampled and edge-detected, so the serial clock must run well below the system clock.

An instruction begins with a 1 start bit. It continues with a two-bit operation code and a seven-bit location, each most significant bit first. A write or a fill with data is followed by eight data bits. Programming happens only after an enable instruction. It starts when the master drops select after a complete programming instruction, and it lasts a parameterised number of system clocks. During that time the device answers select with a low data line and ignores all new traffic. Afterwards it answers with a high line until the next instruction begins.

Top module: `mw_eeprom_model`

## Requirements
- R1: After reset every location holds 0xFF, programming is disabled and `sdo` is low.
- R2: Bits are taken from `sdi` on each rising `sclk` edge while `sel` is high; zeros before the first 1 are skipped, the 1 is the start bit, and it is followed by a 2-bit opcode and a 7-bit location, both most significant bit first.
- R3: Opcode 2'b10 reads: bit 7 of the addressed byte appears on `sdo` after the rising edge that carries the last location bit, and each later rising edge moves to the next lower bit, down to bit 0.
- R4: Opcode 2'b01 writes: 8 data bits follow the location, most significant first, and the byte is stored when `sel` falls after all 8 have arrived.
- R5: Opcode 2'b11 erases the addressed location to 0xFF when `sel` falls after the instruction.
- R6: With opcode 2'b00 the two top location bits select a special instruction: 2'b11 enables programming and 2'b00 disables it; write, erase, erase-all and write-all have no effect while programming is disabled.
- R7: With opcode 2'b00, top location bits 2'b10 set all 128 locations to 0xFF; top bits 2'b01, followed by 8 data bits, write that byte to all 128 locations.
- R8: Programming lasts PROG_CYCLES clocks from the fall of `sel`. While it lasts, `sdo` is low whenever `sel` is high; once it ends, `sdo` is high while `sel` is high, until the next start bit.
- R9: An instruction sent while programming is in progress is ignored and does not change memory.
- R10: Dropping `sel` before an instruction is complete abandons it: memory is unchanged and no programming period starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Device select, active high |
| sclk | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data into the device |
| sdo | output | 1 | Serial data and ready status from the device |

## Verification
The bench builds the model with PROG_CYCLES set to 300 and keeps the default 7-bit location and 8-bit data widths. The whole 128-byte array, including locations 0 and 127, is therefore in play for the bulk operations. A 300-clock programming window is short enough to poll the low phase and then the high phase of the status. It is also long enough to fit a complete write instruction inside it, which puts the ignore-while-busy rule within reach.

// File: rtl/mwe_pkg.sv
// Shared types for the three-wire EEPROM model.
// Assumes opcode and special-instruction codes fixed by the serial protocol.
package mwe_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_RDLOAD,
        ST_RDOUT,
        ST_WRDATA,
        ST_HOLD
    } mwe_state_e;

    localparam logic [1:0] OP_SPECIAL = 2'b00;
    localparam logic [1:0] OP_WRITE   = 2'b01;
    localparam logic [1:0] OP_READ    = 2'b10;
    localparam logic [1:0] OP_ERASE   = 2'b11;

    localparam logic [1:0] SP_DISABLE = 2'b00;
    localparam logic [1:0] SP_FILL    = 2'b01;
    localparam logic [1:0] SP_CLEAR   = 2'b10;
    localparam logic [1:0] SP_ENABLE  = 2'b11;

endpackage

// File: rtl/mwe_pin_sync.sv
// Registers the serial pins and flags rising edges of the serial clock.
// Assumes sclk stays stable for at least two system clocks per phase.
module mwe_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sclk,
    input  logic sdi,
    output logic sel_q,
    output logic sdi_q,
    output logic rise
);
    logic sclk_q;
    logic sclk_qq;

    // capture pins and keep one older copy of the clock for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= 1'b0;
            sdi_q   <= 1'b0;
            sclk_q  <= 1'b0;
            sclk_qq <= 1'b0;
        end else begin
            sel_q   <= sel;
            sdi_q   <= sdi;
            sclk_q  <= sclk;
            sclk_qq <= sclk_q;
        end
    end

    assign rise = sclk_q & ~sclk_qq;

endmodule

// File: rtl/mwe_prog_timer.sv
// Counts the programming period; busy while the count is non-zero.
// Assumes start is never raised while busy (guaranteed by the decoder).
module mwe_prog_timer #(
    parameter int PROG_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int TW = $clog2(PROG_CYCLES + 1);

    logic [TW-1:0] cnt_q;

    // load on start, count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= TW'(PROG_CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);

    // R8
    busy_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R8
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !start) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/mwe_store.sv
// Register-file storage with one read port and a single or whole-array write.
// Assumes erase is expressed by the caller as a write of all ones.
module mwe_store #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_all,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_loc
        // one location: erased on reset, updated when selected or bulk
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q[g] <= '1;
            else if (wr_en && (wr_all || wr_addr == ADDR_W'(g)))
                mem_q[g] <= wr_data;
        end

        // R10
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_en |=> $stable(mem_q[g]));
    end

    assign rd_data = mem_q[rd_addr];

    // R4
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_all) |=> (mem_q[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/mwe_cmd_fsm.sv
// Serial instruction decoder: start bit, opcode, location, data, read shift.
// Assumes pins come registered and rise pulses for one clock per sclk edge.
module mwe_cmd_fsm
    import mwe_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_q,
    input  logic              sdi_q,
    input  logic              rise,
    input  logic              busy,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              prog_start,
    output logic              prog_all,
    output logic [DATA_W-1:0] prog_data,
    output logic              rd_active,
    output logic              rd_bit,
    output logic              status
);
    localparam int CMD_W = ADDR_W + 2;
    localparam int CW    = $clog2(CMD_W);

    mwe_state_e        state_q;
    logic [CW-1:0]     cnt_q;
    logic [CMD_W-2:0]  sh_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] rd_sh_q;
    logic              all_q;
    logic              pend_q;
    logic              wen_q;
    logic              status_q;

    logic [CMD_W-1:0]  full;
    logic [1:0]        op;
    logic [ADDR_W-1:0] loc;
    logic [1:0]        sp;
    logic              start_bit;

    // assemble the instruction word as its last bit arrives
    always_comb begin
        full      = {sh_q, sdi_q};
        op        = full[CMD_W-1 -: 2];
        loc       = full[ADDR_W-1:0];
        sp        = loc[ADDR_W-1 -: 2];
        start_bit = (state_q == ST_IDLE) && sel_q && rise && sdi_q && !busy;
    end

    // instruction sequencing and decode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            sh_q     <= '0;
            addr_q   <= '0;
            data_q   <= '0;
            rd_sh_q  <= '0;
            all_q    <= 1'b0;
            pend_q   <= 1'b0;
            wen_q    <= 1'b0;
        end else if (!sel_q) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_bit) begin
                        state_q <= ST_CMD;
                        cnt_q   <= '0;
                    end
                end
                ST_CMD: begin
                    if (rise) begin
                        sh_q  <= full[CMD_W-2:0];
                        cnt_q <= cnt_q + 1'b1;
                        if (cnt_q == CW'(CMD_W - 1)) begin
                            addr_q <= loc;
                            cnt_q  <= '0;
                            all_q  <= 1'b0;
                            case (op)
                                OP_READ:  state_q <= ST_RDLOAD;
                                OP_WRITE: state_q <= ST_WRDATA;
                                OP_ERASE: begin
                                    data_q  <= '1;
                                    pend_q  <= wen_q;
                                    state_q <= ST_HOLD;
                                end
                                default: begin
                                    state_q <= ST_HOLD;
                                    case (sp)
                                        SP_ENABLE:  wen_q <= 1'b1;
                                        SP_DISABLE: wen_q <= 1'b0;
                                        SP_CLEAR: begin
                                            all_q  <= 1'b1;
                                            data_q <= '1;
                                            pend_q <= wen_q;
                                        end
                                        default: begin
                                            all_q   <= 1'b1;
                                            state_q <= ST_WRDATA;
                                        end
                                    endcase
                                end
                            endcase
                        end
                    end
                end
                ST_RDLOAD: begin
                    rd_sh_q <= rd_data;
                    state_q <= ST_RDOUT;
                end
                ST_RDOUT: begin
                    if (rise) begin
                        cnt_q   <= cnt_q + 1'b1;
                        rd_sh_q <= {rd_sh_q[DATA_W-2:0], 1'b0};
                        if (cnt_q == CW'(DATA_W - 1))
                            state_q <= ST_HOLD;
                    end
                end
                ST_WRDATA: begin
                    if (rise) begin
                        data_q <= {data_q[DATA_W-2:0], sdi_q};
                        cnt_q  <= cnt_q + 1'b1;
                        if (cnt_q == CW'(DATA_W - 1)) begin
                            pend_q  <= wen_q;
                            state_q <= ST_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // ready status: raised by programming, dropped by the next start bit
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= 1'b0;
        else if (prog_start)
            status_q <= 1'b1;
        else if (start_bit)
            status_q <= 1'b0;
    end

    assign prog_start = (state_q == ST_HOLD) && !sel_q && pend_q;
    assign prog_all   = all_q;
    assign prog_data  = data_q;
    assign mem_addr   = addr_q;
    assign rd_active  = (state_q == ST_RDOUT);
    assign rd_bit     = rd_sh_q[DATA_W-1];
    assign status     = status_q;

    // R6
    prog_needs_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> wen_q);

    // R9
    idle_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (state_q == ST_IDLE));

    // R10
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_q && state_q != ST_HOLD) |=> (state_q == ST_IDLE && !pend_q));

endmodule

// File: rtl/mw_eeprom_model.sv
// Top of the three-wire serial EEPROM model: pins, decoder, timer, storage.
// Assumes sclk runs at most at a quarter of clk.
module mw_eeprom_model #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sclk,
    input  logic sdi,
    output logic sdo
);
    logic              sel_q;
    logic              sdi_q;
    logic              rise;
    logic              busy;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] rd_data;
    logic              prog_start;
    logic              prog_all;
    logic [DATA_W-1:0] prog_data;
    logic              rd_active;
    logic              rd_bit;
    logic              status;

    mwe_pin_sync u_pins (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .sclk  (sclk),
        .sdi   (sdi),
        .sel_q (sel_q),
        .sdi_q (sdi_q),
        .rise  (rise)
    );

    mwe_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_q      (sel_q),
        .sdi_q      (sdi_q),
        .rise       (rise),
        .busy       (busy),
        .rd_data    (rd_data),
        .mem_addr   (mem_addr),
        .prog_start (prog_start),
        .prog_all   (prog_all),
        .prog_data  (prog_data),
        .rd_active  (rd_active),
        .rd_bit     (rd_bit),
        .status     (status)
    );

    mwe_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (prog_start),
        .busy  (busy)
    );

    mwe_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (prog_start),
        .wr_all  (prog_all),
        .wr_addr (mem_addr),
        .wr_data (prog_data),
        .rd_addr (mem_addr),
        .rd_data (rd_data)
    );

    // output: read data, else ready status, only while selected
    always_comb begin
        if (!sel_q)
            sdo = 1'b0;
        else if (rd_active)
            sdo = rd_bit;
        else
            sdo = status & ~busy;
    end

    // R8
    busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q && busy) |-> !sdo);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_q |-> !sdo);

endmodule

// File: tb/sim_mw_eeprom_model.sv
// Scoreboard bench: read tasks push expected bytes, a monitor compares results.
module sim_mw_eeprom_model;
    localparam int PROG = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel = 1'b0;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [7:0] ref_mem [128];
    bit         ref_wen = 1'b0;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] got_q [$];

    always #2 clk = ~clk;

    mw_eeprom_model #(.PROG_CYCLES(PROG)) u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sclk(sclk), .sdi(sdi), .sdo(sdo)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // monitor: pop expected items as results appear
    initial begin
        forever begin
            @(negedge clk);
            if (got_q.size() > 0 && exp_q.size() > 0) begin
                automatic logic [7:0] g = got_q.pop_front();
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, g, e);
            end
        end
    end

    task automatic send_bit(input logic b);
        @(negedge clk) sdi = b;
        repeat (2) @(negedge clk);
        sclk = 1'b1;
        repeat (3) @(negedge clk);
        sclk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic cs_on;
        @(negedge clk) sel = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic cs_off;
        @(negedge clk) begin sel = 1'b0; sdi = 1'b0; end
        repeat (3) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic [6:0] a);
        send_bit(1'b1);
        for (int i = 1; i >= 0; i--) send_bit(op[i]);
        for (int i = 6; i >= 0; i--) send_bit(a[i]);
    endtask

    task automatic send_byte(input logic [7:0] d);
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
    endtask

    // poll status: low first, high after the period
    task automatic wait_ready(input string req);
        cs_on;
        repeat (2) @(negedge clk);
        check(req, {7'd0, sdo}, 8'd0);
        repeat (PROG + 20) @(negedge clk);
        check(req, {7'd0, sdo}, 8'd1);
        cs_off;
    endtask

    task automatic do_read(input logic [6:0] a, input string req);
        logic [7:0] v;
        cs_on;
        send_cmd(2'b10, a);
        exp_q.push_back(ref_mem[a]);
        tag_q.push_back(req);
        v = '0;
        for (int i = 0; i < 8; i++) begin
            v = {v[6:0], sdo};
            send_bit(1'b0);
        end
        got_q.push_back(v);
        cs_off;
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d, input string req);
        cs_on;
        send_cmd(2'b01, a);
        send_byte(d);
        cs_off;
        if (ref_wen) begin
            ref_mem[a] = d;
            wait_ready(req);
        end
    endtask

    task automatic do_special(input logic [1:0] sp);
        cs_on;
        send_cmd(2'b00, {sp, 5'b10101});
        cs_off;
        if (sp == 2'b11) ref_wen = 1'b1;
        if (sp == 2'b00) ref_wen = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 128; i++) ref_mem[i] = 8'hFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: quiet output, erased array
        check("R1", {7'd0, sdo}, 8'd0);
        cs_on;
        check("R1", {7'd0, sdo}, 8'd0);
        cs_off;
        do_read(7'd5, "R1");

        // R6: writes ignored before enable
        do_write(7'd3, 8'h5A, "R6");
        cs_on;
        check("R6", {7'd0, sdo}, 8'd0);
        cs_off;
        do_read(7'd3, "R6");

        // R4 / R8: enabled writes with busy polling, edge locations
        do_special(2'b11);
        do_write(7'd3, 8'h5A, "R8");
        do_write(7'd127, 8'hA5, "R4");
        do_write(7'd0, 8'h3C, "R4");
        do_read(7'd3, "R4");
        do_read(7'd127, "R3");
        do_read(7'd0, "R3");

        // R2: leading zeros before the start bit are skipped
        cs_on;
        send_bit(1'b0);
        send_bit(1'b0);
        send_cmd(2'b01, 7'd44);
        send_byte(8'hC3);
        cs_off;
        ref_mem[44] = 8'hC3;
        wait_ready("R2");
        do_read(7'd44, "R2");

        // R9: a complete write during programming is ignored
        cs_on;
        send_cmd(2'b01, 7'd10);
        send_byte(8'h11);
        cs_off;
        ref_mem[10] = 8'h11;
        cs_on;
        send_cmd(2'b01, 7'd10);
        send_byte(8'h22);
        cs_off;
        repeat (PROG) @(negedge clk);
        cs_on;
        check("R9", {7'd0, sdo}, 8'd1);
        cs_off;
        do_read(7'd10, "R9");

        // R5: erase one location
        cs_on;
        send_cmd(2'b11, 7'd3);
        cs_off;
        ref_mem[3] = 8'hFF;
        wait_ready("R5");
        do_read(7'd3, "R5");
        do_read(7'd127, "R5");

        // R10: drop select mid-data
        cs_on;
        send_cmd(2'b01, 7'd20);
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        cs_off;
        cs_on;
        repeat (2) @(negedge clk);
        check("R10", {7'd0, sdo}, 8'd0);
        cs_off;
        do_read(7'd20, "R10");

        // R7: write-all then erase-all
        cs_on;
        send_cmd(2'b00, 7'b01_00000);
        send_byte(8'h96);
        cs_off;
        for (int i = 0; i < 128; i++) ref_mem[i] = 8'h96;
        wait_ready("R7");
        do_read(7'd0, "R7");
        do_read(7'd64, "R7");
        do_read(7'd127, "R7");
        do_special(2'b10);
        for (int i = 0; i < 128; i++) ref_mem[i] = 8'hFF;
        wait_ready("R7");
        do_read(7'd0, "R7");
        do_read(7'd99, "R7");

        // R6: disable, then write and write-all are ignored
        do_write(7'd8, 8'h77, "R6");
        do_special(2'b00);
        do_write(7'd9, 8'h12, "R6");
        cs_on;
        send_cmd(2'b00, 7'b01_00000);
        send_byte(8'h00);
        cs_off;
        do_read(7'd9, "R6");
        do_read(7'd8, "R6");
        do_read(7'd50, "R6");

        repeat (20) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule